// File: doc/BRIEF.md
# Radio Channel Frequency Word Generator

This block turns a channel selection into the target frequency for a radio synthesizer. The frequency is an integer count of 100 kHz units; for example, 868.3 MHz is 8683. There are three ways to select a channel:

- **Standards mode** uses a sparse channel index.
- **Coarse mode** walks a 1 MHz grid.
- **Fine mode** adds an offset, in 100 kHz steps, to the base of one of three bands.

A transmit-select input raises the word by 1 MHz, because the receive and idle frequency sits 1 MHz below the transmit frequency.

All outputs are registered. The valid flag drops for any reserved or out-of-range selection. A one-cycle change strobe tells the synthesizer control that the mode, band or channel has moved, so it can restart calibration. A receive/transmit toggle on its own does not fire the strobe.

Top module: `chan_freq_word`

## Requirements
- R1: While `rst_ni` is low, `freq_o`, `valid_o` and `chg_o` are all 0.
- R2: `mode_i` = 0 selects standards mode. In standards mode, index 0 gives 8683.
- R3: In standards mode, indices 1 to 10 give 9040 + 20·index, which runs from 906 MHz to 924 MHz in 2 MHz steps.
- R4: In standards mode, indices 11 to 255 are reserved and give `valid_o` = 0.
- R5: `mode_i` = 1 selects coarse mode, with word 7690 + 10·chan. It is valid for chan 0 to 166 (769 to 935 MHz) and invalid above 166.
- R6: `mode_i` = 2 selects fine mode, with word base + chan. The band codes and their word ranges are:

  | `band_i` | Base | Last valid word |
  |---|---|---|
  | 0 | 7690 | 7945 |
  | 1 | 8570 | 8825 |
  | 2 | 9020 | 9285 |

  A result above the band's last valid word is invalid. `band_i` = 3 is invalid.
- R7: `mode_i` = 3 is reserved and always gives `valid_o` = 0.
- R8: When a selection is valid and `tx_i` = 1, the word is 10 higher than it is with `tx_i` = 0.
- R9: When `valid_o` = 0, `freq_o` = 0.
- R10: `freq_o` and `valid_o` reflect the inputs present at the preceding rising clock edge.
- R11: `chg_o` is high for exactly the one cycle after an edge at which {`mode_i`, `band_i`, `chan_i`} differs from the value registered at the previous edge. The registered value after reset is all zeros. A change of `tx_i` alone leaves `chg_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Selection mode: 0 standards, 1 coarse, 2 fine, 3 reserved |
| band_i | input | 2 | Fine-mode band code |
| chan_i | input | 8 | Channel index or grid offset |
| tx_i | input | 1 | Transmit select; adds 1 MHz |
| freq_o | output | 14 | Frequency word in 100 kHz units |
| valid_o | output | 1 | Selection is legal |
| chg_o | output | 1 | One-cycle pulse on a selection change |

## Verification
Every result is one register stage from the inputs. The word, the valid flag and the change strobe all become due after the first rising edge following a new input pattern.

The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Each sample is compared against a value computed from the arithmetic in the requirements and from the selection applied one step earlier.

The sweep walks every mode, band, channel and transmit combination. The transmit bit is the innermost loop, so each toggle of `tx_i` with an unchanged selection exercises the no-strobe case.

// File: rtl/chan_freq_pkg.sv
package chan_freq_pkg;
  localparam int FREQ_W     = 14;
  localparam int CHAN_W     = 8;
  localparam int NUM_FBANDS = 3;
  localparam int TX_OFS     = 10;

  typedef enum logic [1:0] {
    MODE_STD    = 2'd0,
    MODE_COARSE = 2'd1,
    MODE_FINE   = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e             mode;
    logic [1:0]        band;
    logic [CHAN_W-1:0] chan;
  } sel_t;

  function automatic int fband_base(int b);
    case (b)
      0:       return 7690;
      1:       return 8570;
      default: return 9020;
    endcase
  endfunction

  function automatic int fband_top(int b);
    case (b)
      0:       return 7945;
      1:       return 8825;
      default: return 9285;
    endcase
  endfunction
endpackage

// File: rtl/chan_std_map.sv
module chan_std_map
  import chan_freq_pkg::*;
#(
  parameter int IDX0_WORD = 8683,
  parameter int GRID_BASE = 9040,
  parameter int GRID_STEP = 20,
  parameter int GRID_LAST = 10
) (
  input  logic [CHAN_W-1:0] idx_i,
  output logic [FREQ_W-1:0] word_o,
  output logic              ok_o
);
  always_comb begin
    word_o = '0;
    ok_o   = 1'b0;
    if (idx_i == '0) begin
      word_o = FREQ_W'(IDX0_WORD);
      ok_o   = 1'b1;
    end else if (32'(idx_i) <= GRID_LAST) begin
      word_o = FREQ_W'(GRID_BASE) + FREQ_W'(GRID_STEP) * FREQ_W'(idx_i);
      ok_o   = 1'b1;
    end
  end
endmodule

// File: rtl/chan_grid_map.sv
module chan_grid_map
  import chan_freq_pkg::*;
#(
  parameter int BASE     = 7690,
  parameter int STEP     = 10,
  parameter int LAST_OFS = 166
) (
  input  logic [CHAN_W-1:0] ofs_i,
  output logic [FREQ_W-1:0] word_o,
  output logic              ok_o
);
  assign word_o = FREQ_W'(BASE) + FREQ_W'(STEP) * FREQ_W'(ofs_i);
  assign ok_o   = (32'(ofs_i) <= LAST_OFS);
endmodule

// File: rtl/chan_sel_tracker.sv
module chan_sel_tracker
  import chan_freq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t sel_i,
  output sel_t sel_q_o,
  output logic chg_o
);
  sel_t sel_q;
  logic chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      chg_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      chg_q <= (sel_i != sel_q);
    end
  end

  assign sel_q_o = sel_q;
  assign chg_o   = chg_q;

  // R11
  chg_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (sel_q != $past(sel_q)));

  // R11
  chg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == $past(sel_q)) |-> !chg_q);
endmodule

// File: rtl/chan_freq_word.sv
module chan_freq_word
  import chan_freq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        band_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              tx_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic              valid_o,
  output logic              chg_o
);
  logic [FREQ_W-1:0] std_word, crs_word, sel_word, nxt_word;
  logic              std_ok, crs_ok, sel_ok;
  logic [FREQ_W-1:0] fine_word [NUM_FBANDS];
  logic              fine_ok   [NUM_FBANDS];
  sel_t              sel_in, sel_q;

  chan_std_map u_std (
    .idx_i  (chan_i),
    .word_o (std_word),
    .ok_o   (std_ok)
  );

  chan_grid_map #(.BASE(7690), .STEP(10), .LAST_OFS(166)) u_coarse (
    .ofs_i  (chan_i),
    .word_o (crs_word),
    .ok_o   (crs_ok)
  );

  for (genvar b = 0; b < NUM_FBANDS; b++) begin : g_fine
    chan_grid_map #(
      .BASE     (fband_base(b)),
      .STEP     (1),
      .LAST_OFS (fband_top(b) - fband_base(b))
    ) u_band (
      .ofs_i  (chan_i),
      .word_o (fine_word[b]),
      .ok_o   (fine_ok[b])
    );
  end

  always_comb begin
    sel_word = '0;
    sel_ok   = 1'b0;
    case (mode_e'(mode_i))
      MODE_STD: begin
        sel_word = std_word;
        sel_ok   = std_ok;
      end
      MODE_COARSE: begin
        sel_word = crs_word;
        sel_ok   = crs_ok;
      end
      MODE_FINE: begin
        for (int b = 0; b < NUM_FBANDS; b++) begin
          if (32'(band_i) == b) begin
            sel_word = fine_word[b];
            sel_ok   = fine_ok[b];
          end
        end
      end
      default: ;
    endcase
  end

  // invalid selections publish a zero word
  assign nxt_word = !sel_ok ? '0
                  : (tx_i ? sel_word + FREQ_W'(TX_OFS) : sel_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      freq_o  <= nxt_word;
      valid_o <= sel_ok;
    end
  end

  assign sel_in = '{mode: mode_e'(mode_i), band: band_i, chan: chan_i};

  chan_sel_tracker u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_in),
    .sel_q_o (sel_q),
    .chg_o   (chg_o)
  );

  // R9
  zero_when_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (freq_o == '0));

  // R5
  freq_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (freq_o >= FREQ_W'(7690) && freq_o <= FREQ_W'(9360)));

  // R5
  coarse_grid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sel_q.mode == MODE_COARSE) |-> (freq_o % FREQ_W'(10) == '0));

  // R7
  rsvd_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q.mode == MODE_RSVD) |-> !valid_o);
endmodule

// File: tb/tb_chan_freq_word.sv
`timescale 1ns/1ps
module tb_chan_freq_word;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  band = '0;
  logic [7:0]  chan = '0;
  logic        tx = 1'b0;
  logic [13:0] freq;
  logic        valid, chg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_freq_word dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .mode_i  (mode),
    .band_i  (band),
    .chan_i  (chan),
    .tx_i    (tx),
    .freq_o  (freq),
    .valid_o (valid),
    .chg_o   (chg)
  );

  // returns -1 for an invalid selection
  function automatic int model(int m, int b, int c, int t);
    int w;
    w = -1;
    if (m == 0) begin
      if (c == 0) w = 8683;                  // R2
      else if (c <= 10) w = 9060 + 20 * (c - 1); // R3
    end else if (m == 1) begin
      if (c <= 166) w = (769 + c) * 10;      // R5
    end else if (m == 2) begin
      int base, top;                          // R6
      base = (b == 0) ? 7690 : (b == 1) ? 8570 : 9020;
      top  = (b == 0) ? 7945 : (b == 1) ? 8825 : 9285;
      if (b != 3 && base + c <= top) w = base + c;
    end
    if (w >= 0 && t == 1) w = w + 10;        // R8
    return w;
  endfunction

  function automatic string tag(int m, int c);
    if (m == 0) return (c == 0) ? "R2" : (c <= 10) ? "R3" : "R4";
    if (m == 1) return "R5";
    if (m == 2) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [13:0] f, logic v, logic s,
                       int ef, int ev, int es);
    checks++;
    if (f !== 14'(ef) || v !== 1'(ev) || s !== 1'(es)) begin
      errors++;
      $display("FAIL %s: got freq=%0d valid=%0d chg=%0d, expected freq=%0d valid=%0d chg=%0d",
               req, f, v, s, ef, ev, es);
    end
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pm, pb, pc;
    mode = 2'd1;
    chan = 8'd5;
    tx   = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", freq, valid, chg, 0, 0, 0);
    @(negedge clk);
    mode  = '0;
    chan  = '0;
    tx    = 1'b0;
    rst_n = 1'b1;
    pm = 0; pb = 0; pc = 0;
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 4; b++) begin
        for (int c = 0; c < 256; c++) begin
          for (int t = 0; t < 2; t++) begin
            int w, es;
            @(negedge clk);
            mode = 2'(m);
            band = 2'(b);
            chan = 8'(c);
            tx   = 1'(t);
            es = (m != pm || b != pb || c != pc) ? 1 : 0; // R11
            pm = m; pb = b; pc = c;
            @(posedge clk);
            #1;
            w = model(m, b, c, t);
            // R9 zero word when invalid, R10 one-cycle latency
            check($sformatf("%s R8 R9 R10 R11", tag(m, c)), freq, valid, chg,
                  (w < 0) ? 0 : w, (w < 0) ? 0 : 1, es);
          end
        end
      end
    end
    // R11 a held selection stops the strobe after one cycle
    @(negedge clk);
    @(posedge clk);
    #1 check("R11", freq, valid, chg, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule